// File: doc/BRIEF.md
# Recirculating Montgomery Modular Multiplier

This block forms a Montgomery modular product with a single row of digit cells that is used again for every digit of the multiplier. A start pulse captures the operands A, B and the odd modulus M, together with one precomputed digit: the multiplicative inverse of (r - M[0]) modulo the radix r = 2^DIGIT_W. The running partial product starts at zero. On each later clock the row consumes one digit of A, least significant first, and adds the matching multiples of B and M. It then shifts the sum down by one digit and writes it back into the partial-product register that feeds the row's input.

After n digits of A, the row runs one further pass with an implied zero digit. The register then holds P, which is congruent to A·B·r^-(n+1) modulo M and is less than 2M. A one-cycle done pulse marks the result. The result stays on the output until the next operation is started. Removing the r^-(n+1) factor and subtracting the possible extra M are left to the surrounding logic.

Top module: `mm_recirc_mult`

## Requirements
- R1: During and after reset, busy_o and done_o are low and p_o is zero.
- R2: A start_i sampled high while busy_o is low captures a_i, b_i, m_i and minv_i and raises busy_o on that same edge.
- R3: done_o goes high exactly N_DIGITS+1 clock edges after the accepting edge and stays high for one cycle only. busy_o falls on the edge that raises done_o.
- R4: Let M be odd, B < 2M, and minv_i·(r - M mod r) ≡ 1 (mod r). At done_o, p_o ≡ A·B·r^-(N_DIGITS+1) (mod M).
- R5: Under the conditions of R4, p_o < 2M at done_o.
- R6: start_i sampled high while busy_o is high is ignored. The running operation ends at its original time with its original result.
- R7: While busy_o is low and start_i is low, p_o does not change.
- R8: If A = 0 or B = 0, the result is exactly 0.
- R9: Changes on a_i, b_i, m_i and minv_i after the accepting edge do not affect the running operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only when idle |
| a_i | input | N_DIGITS*DIGIT_W | Multiplier A, digit 0 in the low bits |
| b_i | input | (M_DIGITS+1)*DIGIT_W | Multiplicand B, must satisfy B < 2M |
| m_i | input | M_DIGITS*DIGIT_W | Odd modulus M |
| minv_i | input | DIGIT_W | Inverse of (r - M[0]) modulo r |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| p_o | output | (M_DIGITS+2)*DIGIT_W | Partial product register, final result after done |

## Verification
The bench builds the block with DIGIT_W = 2 (radix 4), N_DIGITS = 4 and M_DIGITS = 4. Every operand then fits in a machine integer, so the bench can compute the expected residue with an exhaustive modular-inverse search for 4^5. At this size a five-pass run takes only a few cycles, so extreme moduli are cheap to cover: M = 1, M = 255, all-ones A, and B close to 2M, which pushes the carries to their bounds. A start that arrives while busy and operand changes during a run can also be placed in any pass.

// File: rtl/mm_pkg.sv
package mm_pkg;
   // carry out of one digit cell needs one bit more than a digit
   function automatic int unsigned carry_w(input int unsigned dw);
      return dw + 1;
   endfunction
   // widest cell sum: digit + two digit products + carry
   function automatic int unsigned sum_w(input int unsigned dw);
      return 2 * dw + 1;
   endfunction
endpackage

// File: rtl/mm_q_cell.sv
module mm_q_cell
   import mm_pkg::*;
#(
   parameter int unsigned DIGIT_W = 2,
   localparam int unsigned CW = carry_w(DIGIT_W),
   localparam int unsigned SW = sum_w(DIGIT_W)
) (
   input  logic [DIGIT_W-1:0] p_lo_i,
   input  logic [DIGIT_W-1:0] a_dig_i,
   input  logic [DIGIT_W-1:0] b_lo_i,
   input  logic [DIGIT_W-1:0] m_lo_i,
   input  logic [DIGIT_W-1:0] minv_i,
   output logic [DIGIT_W-1:0] q_o,
   output logic [CW-1:0]      c_o
);
   logic [SW-1:0]      part;
   logic [SW-1:0]      full;
   logic [DIGIT_W-1:0] q;

   always_comb begin
      part = SW'(p_lo_i) + SW'(a_dig_i) * SW'(b_lo_i);
      q    = part[DIGIT_W-1:0] * minv_i;
      full = part + SW'(q) * SW'(m_lo_i);
   end

   assign q_o = q;
   // low digit of full is zero by choice of q; only the carry moves on
   assign c_o = CW'(full >> DIGIT_W);
endmodule

// File: rtl/mm_digit_cell.sv
module mm_digit_cell
   import mm_pkg::*;
#(
   parameter int unsigned DIGIT_W = 2,
   localparam int unsigned CW = carry_w(DIGIT_W),
   localparam int unsigned SW = sum_w(DIGIT_W)
) (
   input  logic [DIGIT_W-1:0] p_i,
   input  logic [DIGIT_W-1:0] a_dig_i,
   input  logic [DIGIT_W-1:0] b_i,
   input  logic [DIGIT_W-1:0] q_i,
   input  logic [DIGIT_W-1:0] m_i,
   input  logic [CW-1:0]      c_i,
   output logic [DIGIT_W-1:0] d_o,
   output logic [CW-1:0]      c_o
);
   logic [SW-1:0] sum;

   assign sum = SW'(p_i) + SW'(a_dig_i) * SW'(b_i)
              + SW'(q_i) * SW'(m_i) + SW'(c_i);
   assign d_o = sum[DIGIT_W-1:0];
   assign c_o = sum[SW-1:DIGIT_W];
endmodule

// File: rtl/mm_row.sv
module mm_row
   import mm_pkg::*;
#(
   parameter int unsigned DIGIT_W  = 2,
   parameter int unsigned M_DIGITS = 4,
   localparam int unsigned PD = M_DIGITS + 2,
   localparam int unsigned CW = carry_w(DIGIT_W)
) (
   input  logic [PD*DIGIT_W-1:0]           p_i,
   input  logic [DIGIT_W-1:0]              a_dig_i,
   input  logic [(M_DIGITS+1)*DIGIT_W-1:0] b_i,
   input  logic [M_DIGITS*DIGIT_W-1:0]     m_i,
   input  logic [DIGIT_W-1:0]              minv_i,
   output logic [PD*DIGIT_W-1:0]           p_next_o
);
   logic [PD*DIGIT_W-1:0] b_ext;
   logic [PD*DIGIT_W-1:0] m_ext;
   logic [DIGIT_W-1:0]    q;
   logic [CW-1:0]         carry [PD];

   assign b_ext = {{DIGIT_W{1'b0}}, b_i};
   assign m_ext = {{(2*DIGIT_W){1'b0}}, m_i};

   for (genvar j = 0; j < PD; j++) begin : g_cell
      if (j == 0) begin : g_right
         mm_q_cell #(.DIGIT_W(DIGIT_W)) i_cell (
            .p_lo_i (p_i[DIGIT_W-1:0]),
            .a_dig_i(a_dig_i),
            .b_lo_i (b_ext[DIGIT_W-1:0]),
            .m_lo_i (m_ext[DIGIT_W-1:0]),
            .minv_i (minv_i),
            .q_o    (q),
            .c_o    (carry[0])
         );
      end else begin : g_typ
         mm_digit_cell #(.DIGIT_W(DIGIT_W)) i_cell (
            .p_i    (p_i[j*DIGIT_W +: DIGIT_W]),
            .a_dig_i(a_dig_i),
            .b_i    (b_ext[j*DIGIT_W +: DIGIT_W]),
            .q_i    (q),
            .m_i    (m_ext[j*DIGIT_W +: DIGIT_W]),
            .c_i    (carry[j-1]),
            .d_o    (p_next_o[(j-1)*DIGIT_W +: DIGIT_W]),
            .c_o    (carry[j])
         );
      end
   end

   // the shift down leaves the top carry as the new top digit
   assign p_next_o[(PD-1)*DIGIT_W +: DIGIT_W] = DIGIT_W'(carry[PD-1]);
endmodule

// File: rtl/mm_recirc_mult.sv
module mm_recirc_mult #(
   parameter int unsigned DIGIT_W  = 2,
   parameter int unsigned N_DIGITS = 4,
   parameter int unsigned M_DIGITS = 4
) (
   input  logic                             clk_i,
   input  logic                             rst_ni,
   input  logic                             start_i,
   input  logic [N_DIGITS*DIGIT_W-1:0]      a_i,
   input  logic [(M_DIGITS+1)*DIGIT_W-1:0]  b_i,
   input  logic [M_DIGITS*DIGIT_W-1:0]      m_i,
   input  logic [DIGIT_W-1:0]               minv_i,
   output logic                             busy_o,
   output logic                             done_o,
   output logic [(M_DIGITS+2)*DIGIT_W-1:0]  p_o
);
   localparam int unsigned PD = M_DIGITS + 2;
   localparam int unsigned PW = $clog2(N_DIGITS + 1) + 1;
   localparam int unsigned AW = N_DIGITS * DIGIT_W;

   if (DIGIT_W < 2) begin : g_bad_radix
      $error("DIGIT_W must be at least 2 so that 3M fits the register");
   end
   if (N_DIGITS < 1 || M_DIGITS < 1) begin : g_bad_len
      $error("operand lengths must be at least one digit");
   end

   logic [AW-1:0]                 a_q;
   logic [(M_DIGITS+1)*DIGIT_W-1:0] b_q;
   logic [M_DIGITS*DIGIT_W-1:0]   m_q;
   logic [DIGIT_W-1:0]            minv_q;
   logic [PD*DIGIT_W-1:0]         p_q;
   logic [PD*DIGIT_W-1:0]         p_next;
   logic [PW-1:0]                 pass_q;
   logic                          busy_q;
   logic                          done_q;
   logic [AW+DIGIT_W-1:0]         a_ext;
   logic [DIGIT_W-1:0]            a_dig;

   // A padded with its zero top digit for the final pass
   assign a_ext = {{DIGIT_W{1'b0}}, a_q};
   assign a_dig = a_ext[int'(pass_q)*DIGIT_W +: DIGIT_W];

   mm_row #(.DIGIT_W(DIGIT_W), .M_DIGITS(M_DIGITS)) i_row (
      .p_i     (p_q),
      .a_dig_i (a_dig),
      .b_i     (b_q),
      .m_i     (m_q),
      .minv_i  (minv_q),
      .p_next_o(p_next)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         a_q    <= '0;
         b_q    <= '0;
         m_q    <= '0;
         minv_q <= '0;
         p_q    <= '0;
         pass_q <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q && start_i) begin
            a_q    <= a_i;
            b_q    <= b_i;
            m_q    <= m_i;
            minv_q <= minv_i;
            p_q    <= '0;
            pass_q <= '0;
            busy_q <= 1'b1;
         end else if (busy_q) begin
            p_q <= p_next;
            if (pass_q == PW'(N_DIGITS)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               pass_q <= pass_q + 1'b1;
            end
         end
      end
   end

   assign busy_o = busy_q;
   assign done_o = done_q;
   assign p_o    = p_q;
endmodule

// File: rtl/mm_recirc_mult_chk.sv
module mm_recirc_mult_chk #(
   parameter int unsigned DIGIT_W  = 2,
   parameter int unsigned N_DIGITS = 4,
   parameter int unsigned M_DIGITS = 4
) (
   input logic                            clk_i,
   input logic                            rst_ni,
   input logic                            start_i,
   input logic                            busy_o,
   input logic                            done_o,
   input logic [(M_DIGITS+2)*DIGIT_W-1:0] p_o,
   input logic [M_DIGITS*DIGIT_W-1:0]     m_q
);
   localparam int unsigned CNT_W = $clog2(N_DIGITS + 2) + 1;
   logic [CNT_W-1:0] run_cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 run_cnt <= '0;
      else if (start_i && !busy_o) run_cnt <= '0;
      else if (busy_o)             run_cnt <= run_cnt + 1'b1;
   end

   AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !busy_o) |=> busy_o); // R2
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R3
   AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (run_cnt == CNT_W'(N_DIGITS + 1) && !busy_o)); // R3
   AST_RESULT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (p_o < {{(2*DIGIT_W-1){1'b0}}, m_q, 1'b0})); // R5
   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && !start_i) |=> $stable(p_o)); // R7
endmodule

bind mm_recirc_mult mm_recirc_mult_chk #(
   .DIGIT_W(DIGIT_W), .N_DIGITS(N_DIGITS), .M_DIGITS(M_DIGITS)
) i_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .start_i(start_i),
   .busy_o (busy_o),
   .done_o (done_o),
   .p_o    (p_o),
   .m_q    (m_q)
);

// File: tb/test_mm_recirc_mult.sv
`timescale 1ns/1ps
module test_mm_recirc_mult;
   localparam int unsigned DW = 2;
   localparam int unsigned ND = 4;
   localparam int unsigned MD = 4;
   localparam int unsigned AW = ND*DW;
   localparam int unsigned BW = (MD+1)*DW;
   localparam int unsigned MW = MD*DW;
   localparam int unsigned PW = (MD+2)*DW;
   localparam int unsigned LAT = ND + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [AW-1:0] a_i = '0;
   logic [BW-1:0] b_i = '0;
   logic [MW-1:0] m_i = '0;
   logic [DW-1:0] minv_i = '0;
   logic busy_o, done_o;
   logic [PW-1:0] p_o;

   int n_checks = 0;
   int n_errors = 0;

   always #2.5 clk = ~clk;

   mm_recirc_mult #(.DIGIT_W(DW), .N_DIGITS(ND), .M_DIGITS(MD)) i_mm_recirc_mult (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .a_i(a_i), .b_i(b_i),
      .m_i(m_i), .minv_i(minv_i), .busy_o(busy_o), .done_o(done_o), .p_o(p_o)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] inv_digit(input logic [MW-1:0] m);
      int r = 1 << DW;
      int neg = (r - int'(m[DW-1:0])) % r;
      for (int x = 0; x < r; x++)
         if (((neg * x) % r) == 1) return DW'(x);
      return '0;
   endfunction

   // A*B*r^-(ND+1) mod M, found by search for the inverse of r^(ND+1)
   function automatic longint ref_res(input longint a, input longint b, input longint m);
      longint rp = longint'(1) << (DW*LAT);
      if (m == 1) return 0;
      for (longint x = 0; x < m; x++)
         if ((((rp % m) * x) % m) == 1) return (((a * b) % m) * x) % m;
      return -1;
   endfunction

   task automatic launch(input longint a, input longint b, input longint m);
      @(negedge clk);
      a_i = AW'(a); b_i = BW'(b); m_i = MW'(m); minv_i = inv_digit(MW'(m));
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_done(output int cyc);
      cyc = 0;
      while (!done_o && cyc < 50) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic check_result(input longint a, input longint b, input longint m, input string tag);
      longint e = ref_res(a, b, m);
      longint p = longint'(p_o);
      chk((p % m) == e, {"R4 ", tag}, p % m, e);
      chk(p < 2*m, {"R5 ", tag}, p, 2*m);
   endtask

   task automatic t_reset();
      chk(!busy_o && !done_o, "R1 flags", {busy_o, done_o}, 0);
      chk(p_o == '0, "R1 p_o", p_o, 0);
   endtask

   task automatic t_op(input longint a, input longint b, input longint m, input string tag);
      int cyc;
      launch(a, b, m);
      chk(busy_o == 1'b1, {"R2 busy ", tag}, busy_o, 1);
      wait_done(cyc);
      chk(cyc == LAT, {"R3 latency ", tag}, cyc, LAT);
      check_result(a, b, m, tag);
      @(negedge clk);
      chk(!done_o && !busy_o, {"R3 pulse ", tag}, done_o, 0);
   endtask

   task automatic t_zero(input longint a, input longint b, input longint m, input string tag);
      int cyc;
      launch(a, b, m);
      wait_done(cyc);
      chk(p_o == '0, {"R8 ", tag}, p_o, 0);
   endtask

   task automatic t_busy_start();
      int cyc;
      launch(90, 291, 183);
      @(negedge clk);
      start_i = 1'b1; a_i = 8'hFF; b_i = 10'h1FD; m_i = 8'hFF; minv_i = inv_digit(8'hFF);
      @(negedge clk);
      start_i = 1'b0;
      wait_done(cyc);
      chk(cyc == LAT - 2, "R6 done timing", cyc + 2, LAT);
      check_result(90, 291, 183, "R6 result");
   endtask

   task automatic t_operand_change();
      int cyc;
      launch(200, 300, 199);
      a_i = 8'h11; b_i = 10'h3; m_i = 8'h07; minv_i = inv_digit(8'h07);
      @(negedge clk);
      a_i = 8'hEE; b_i = 10'h2A5;
      wait_done(cyc);
      chk(cyc == LAT - 1, "R9 timing", cyc + 1, LAT);
      check_result(200, 300, 199, "R9 result");
   endtask

   task automatic t_hold();
      logic [PW-1:0] held;
      int cyc;
      launch(77, 150, 97);
      wait_done(cyc);
      held = p_o;
      a_i = 8'h00; b_i = 10'h000;
      repeat (4) @(negedge clk);
      chk(p_o == held, "R7 hold", p_o, held);
   endtask

   initial begin
      #(200000 * 5);
      chk(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #1;
      t_reset();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_op(90, 291, 183, "mid");
      t_op(255, 509, 255, "max");
      t_op(1, 1, 1, "m1");
      t_op(171, 100, 131, "alt");
      t_op(255, 2, 3, "small m");
      t_zero(0, 300, 129, "a zero");
      t_zero(255, 0, 197, "b zero");
      t_busy_start();
      t_operand_change();
      t_hold();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule